// File: doc/BRIEF.md
# Extended-Mode Operand Address Generator

This unit sits behind instruction fetch in a small accumulator-style processor. It works on an instruction whose first bytes have already been fetched. It produces the instruction's length in bytes and the operand that execution will use. Depending on two mode flags, that operand is one of three things:

- an immediate value;
- an effective address;
- an address loaded from memory through one indirect word read.

The caller presents the flag bits and the address field as separate ports, together with the current program counter, base register and index register, and pulses `start`. Register-only instruction forms are flagged through `short_len`. Such forms finish without any address arithmetic.

Non-indirect results appear with `done` one clock after `start`. Indirect results appear one clock after the memory port acknowledges its read. All outputs hold their value until the next accepted `start`. Opcode execution is handled elsewhere.

Top module: `xaddr_gen`

## Requirements
- R1: After reset, `done`, `mem_req`, `imm_valid` and `err` are 0, and `len` and `addr` are 0.
- R2: When `short_len` is 1 or 2 at `start`, `done` rises one cycle later with `len` equal to `short_len`, `addr` = 0, `imm_valid` = 0, `err` = 0, and no memory read.
- R3: With either mode flag set, `e`=0, `b`=1 and `p`=0, the address is `base_reg` plus the zero-extended `field[11:0]`, modulo 2^20, and `len` = 3.
- R4: With either mode flag set, `e`=0, `b`=0 and `p`=1, the address is `pc` + 3 plus the sign-extended `field[11:0]`, modulo 2^20; `pc` is the address of the current instruction.
- R5: With either mode flag set, `e`=0 and `b`=`p`=0, the address is the zero-extended `field[11:0]`. In every mode, `x`=1 adds `idx_reg` modulo 2^20 to the computed address.
- R6: With either mode flag set and `e`=1, `len` = 4 and the address is the full 20-bit `field` (plus `idx_reg` when `x`=1). `b` and `p` do not offset it.
- R7: With `n`=0 and `i`=1, `imm_valid` = 1, `addr` carries the computed value, and no memory read is made.
- R8: With `n`=1 and `i`=0, exactly one read is issued at the computed address. `addr` becomes `mem_rdata[19:0]`, and `done` rises one cycle after the `mem_ack` edge. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R9: With `n`=0 and `i`=0 (compatibility mode), the address is the 15-bit value {`b`,`p`,`e`,`field[11:0]`} (plus `idx_reg` when `x`=1), `len` = 3 and `imm_valid` = 0.
- R10: With either mode flag set and `b`=`p`=1, `err` = 1, `addr` = 0, `imm_valid` = 0, and no read is made; `done` rises one cycle after `start`.
- R11: A `start` that arrives while a read is pending is ignored. `len`, `err` and the final `addr` belong to the earlier request, and no extra `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; fields are sampled on this edge |
| short_len | input | 2 | 0 = memory-referencing form; 1 or 2 = register-only form of that length |
| f_n | input | 1 | Indirect-mode flag |
| f_i | input | 1 | Immediate-mode flag |
| f_x | input | 1 | Index-add flag |
| f_b | input | 1 | Base-relative flag |
| f_p | input | 1 | PC-relative flag |
| f_e | input | 1 | Long-form flag |
| field | input | 20 | Address field; bits [11:0] in the 3-byte form, all bits in the 4-byte form |
| pc | input | 20 | Address of the current instruction |
| base_reg | input | 20 | Base register value |
| idx_reg | input | 20 | Index register value |
| done | output | 1 | One-cycle pulse when the result is valid |
| len | output | 3 | Instruction length in bytes |
| imm_valid | output | 1 | `addr` holds an immediate operand |
| err | output | 1 | Illegal flag combination |
| addr | output | 20 | Final address or immediate value |
| mem_req | output | 1 | Indirect read request, held until acknowledged |
| mem_addr | output | 20 | Indirect read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 24 | Read word; low 20 bits are used |

## Verification
A wrong mode decode shows up on the very next `done` as a wrong `len`, `imm_valid` or `err`, or as a memory read that should not occur, or one that is missing. An adder selection fault is visible only for the mode it corrupts, so every addressing mode is driven with values that wrap modulo 2^20 or exercise the sign of the displacement. A stuck or stale read-pending state shows up within a few cycles as a missing `done`, a duplicate `done`, or a request that is accepted while a read is outstanding.

// File: rtl/xag_pkg.sv
package xag_pkg;
   typedef enum logic [1:0] {
      K_LEGACY = 2'b00,
      K_IMM    = 2'b01,
      K_IND    = 2'b10,
      K_SIMPLE = 2'b11
   } xag_kind_t;
endpackage

// File: rtl/xag_decode.sv
module xag_decode
   import xag_pkg::*;
#(
   parameter bit HAS_LONG = 1'b1
) (
   input  logic       f_n,
   input  logic       f_i,
   input  logic       f_b,
   input  logic       f_p,
   input  logic       f_e,
   input  logic [1:0] short_len,
   output xag_kind_t  kind,
   output logic       is_short,
   output logic       illegal,
   output logic       needs_read,
   output logic       long_sel,
   output logic [2:0] len
);
   assign kind     = xag_kind_t'({f_n, f_i});
   assign is_short = (short_len != 2'd0);

   generate
      if (HAS_LONG) begin : g_long
         assign long_sel = f_e && (kind != K_LEGACY);
      end else begin : g_nolong
         assign long_sel = 1'b0;
      end
   endgenerate

   assign illegal    = !is_short && (kind != K_LEGACY) && f_b && f_p;
   assign needs_read = !is_short && !illegal && (kind == K_IND);

   always_comb begin
      if (is_short)      len = {1'b0, short_len};
      else if (long_sel) len = 3'd4;
      else               len = 3'd3;
   end
endmodule

// File: rtl/xag_ea.sv
module xag_ea
   import xag_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 12,
   parameter int LW = 15
) (
   input  xag_kind_t        kind,
   input  logic             long_sel,
   input  logic             f_x,
   input  logic             f_b,
   input  logic             f_p,
   input  logic             f_e,
   input  logic [AW-1:0]    field,
   input  logic [AW-1:0]    pc,
   input  logic [AW-1:0]    base_reg,
   input  logic [AW-1:0]    idx_reg,
   output logic [AW-1:0]    ta
);
   localparam int PAD_D = AW - DW;
   localparam int PAD_L = AW - LW;

   generate
      if (LW != DW + 3) begin : g_bad_lw
         $error("legacy width must be displacement width plus three flag bits");
      end
      if (AW <= LW) begin : g_bad_aw
         $error("address width must exceed legacy width");
      end
   endgenerate

   logic [AW-1:0] dsp_u, dsp_s, legacy_a, pc_next, base_sum;

   assign dsp_u    = {{PAD_D{1'b0}}, field[DW-1:0]};
   assign dsp_s    = {{PAD_D{field[DW-1]}}, field[DW-1:0]};
   assign legacy_a = {{PAD_L{1'b0}}, f_b, f_p, f_e, field[DW-1:0]};
   assign pc_next  = pc + AW'(3);

   always_comb begin
      if (kind == K_LEGACY)   base_sum = legacy_a;
      else if (long_sel)      base_sum = field;
      else begin
         unique case ({f_b, f_p})
            2'b10:   base_sum = base_reg + dsp_u;
            2'b01:   base_sum = pc_next + dsp_s;
            default: base_sum = dsp_u;
         endcase
      end
      ta = base_sum + (f_x ? idx_reg : '0);
   end
endmodule

// File: rtl/xag_indirect.sv
module xag_indirect #(
   parameter int AW = 20,
   parameter int WW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] ta,
   input  logic          mem_ack,
   input  logic [WW-1:0] mem_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          fetch_done,
   output logic [AW-1:0] fetched
);
   generate
      if (WW < AW) begin : g_bad_ww
         $error("word width must hold a full address");
      end
   endgenerate

   logic unused_hi;
   assign unused_hi = ^mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req  <= 1'b0;
         mem_addr <= '0;
      end else if (launch) begin
         mem_req  <= 1'b1;
         mem_addr <= ta;
      end else if (mem_req && mem_ack) begin
         mem_req  <= 1'b0;
      end
   end

   assign fetch_done = mem_req && mem_ack;
   assign fetched    = mem_rdata[AW-1:0];

   // R8: request and address stay put until acknowledged
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R8: a new read is never launched while one is pending
   a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !launch);
endmodule

// File: rtl/xaddr_gen.sv
module xaddr_gen
   import xag_pkg::*;
#(
   parameter int AW       = 20,
   parameter int WW       = 24,
   parameter int DW       = 12,
   parameter int LW       = 15,
   parameter bit HAS_LONG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    short_len,
   input  logic          f_n,
   input  logic          f_i,
   input  logic          f_x,
   input  logic          f_b,
   input  logic          f_p,
   input  logic          f_e,
   input  logic [AW-1:0] field,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] base_reg,
   input  logic [AW-1:0] idx_reg,
   output logic          done,
   output logic [2:0]    len,
   output logic          imm_valid,
   output logic          err,
   output logic [AW-1:0] addr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [WW-1:0] mem_rdata
);
   xag_kind_t     kind;
   logic          is_short, illegal, needs_read, long_sel, accept, launch;
   logic          fetch_done;
   logic [2:0]    dec_len;
   logic [AW-1:0] ta, fetched;

   xag_decode #(.HAS_LONG(HAS_LONG)) u_dec (
      .f_n(f_n), .f_i(f_i), .f_b(f_b), .f_p(f_p), .f_e(f_e),
      .short_len(short_len), .kind(kind), .is_short(is_short),
      .illegal(illegal), .needs_read(needs_read), .long_sel(long_sel),
      .len(dec_len)
   );

   xag_ea #(.AW(AW), .DW(DW), .LW(LW)) u_ea (
      .kind(kind), .long_sel(long_sel), .f_x(f_x), .f_b(f_b), .f_p(f_p),
      .f_e(f_e), .field(field), .pc(pc), .base_reg(base_reg),
      .idx_reg(idx_reg), .ta(ta)
   );

   assign accept = start && !mem_req;
   assign launch = accept && needs_read;

   xag_indirect #(.AW(AW), .WW(WW)) u_ind (
      .clk(clk), .rst_n(rst_n), .launch(launch), .ta(ta),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .fetch_done(fetch_done), .fetched(fetched)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         len       <= 3'd0;
         imm_valid <= 1'b0;
         err       <= 1'b0;
         addr      <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            len       <= dec_len;
            imm_valid <= !is_short && !illegal && (kind == K_IMM);
            err       <= illegal;
            if (!needs_read) begin
               done <= 1'b1;
               addr <= (is_short || illegal) ? '0 : ta;
            end
         end else if (fetch_done) begin
            done <= 1'b1;
            addr <= fetched;
         end
      end
   end

   // R8: a result is never reported while a read is still outstanding
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);
   // R10: an illegal combination reports a zero address and no immediate
   a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (addr == '0 && !imm_valid));
   // R2: register-only forms carry no address, immediate or error
   a_r2_short_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (done && len < 3'd3) |-> (addr == '0 && !imm_valid && !err));
   // R11: a start during a pending read leaves the captured results alone
   a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && start) |=> ($stable(len) && $stable(err) && $stable(imm_valid)));
   // R6: a reported length is always one of the legal sizes
   a_r6_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (len >= 3'd1 && len <= 3'd4));
endmodule

// File: tb/sim_xaddr_gen.sv
module sim_xaddr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  short_len = 2'd0;
   logic        f_n = 0, f_i = 0, f_x = 0, f_b = 0, f_p = 0, f_e = 0;
   logic [19:0] field = '0, pc = '0, base_reg = '0, idx_reg = '0;
   logic        done, imm_valid, err, mem_req;
   logic [2:0]  len;
   logic [19:0] addr, mem_addr;
   logic        mem_ack = 1'b0;
   logic [23:0] mem_rdata = '0;

   always #5 clk = ~clk;

   xaddr_gen u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .short_len(short_len),
      .f_n(f_n), .f_i(f_i), .f_x(f_x), .f_b(f_b), .f_p(f_p), .f_e(f_e),
      .field(field), .pc(pc), .base_reg(base_reg), .idx_reg(idx_reg),
      .done(done), .len(len), .imm_valid(imm_valid), .err(err),
      .addr(addr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   typedef struct {
      string       tag;
      logic [19:0] addr;
      logic [2:0]  len;
      logic        imm;
      logic        err;
      int          reads;
      logic [19:0] ra;
      int          cyc0;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0, fails = 0;
   int cyc = 0, rd_cnt = 0, rd_mark = 0;
   logic [19:0] last_ra = '0;
   int wait_cnt = 0;
   bit finished = 0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (mem_req && mem_ack) begin
         rd_cnt  = rd_cnt + 1;
         last_ra = mem_addr;
      end
   end

   // memory model: acknowledges two cycles after a request appears
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (mem_req) begin
         if (wait_cnt == 1) begin
            mem_ack   <= 1'b1;
            mem_rdata <= {4'hC, mem_addr ^ 20'h35A5A};
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   // monitor: pop and compare each reported result
   always @(negedge clk) begin
      if (rst_n && done) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected done: addr=%h expected no result", addr);
         end else begin
            exp_t e;
            int nrd;
            e = exp_q.pop_front();
            nrd = rd_cnt - rd_mark;
            rd_mark = rd_cnt;
            if (addr !== e.addr || len !== e.len || imm_valid !== e.imm ||
                err !== e.err || nrd != e.reads ||
                (e.reads == 1 && last_ra !== e.ra) ||
                (e.reads == 0 && cyc - e.cyc0 != 1)) begin
               fails++;
               $display("FAIL %s: addr=%h len=%0d imm=%b err=%b reads=%0d ra=%h lat=%0d expected addr=%h len=%0d imm=%b err=%b reads=%0d ra=%h",
                        e.tag, addr, len, imm_valid, err, nrd, last_ra, cyc - e.cyc0,
                        e.addr, e.len, e.imm, e.err, e.reads, e.ra);
            end
         end
      end
   end

   function automatic logic [19:0] ref_ta(logic n, logic i, logic x, logic b,
                                          logic p, logic e, logic [19:0] fld);
      logic [19:0] t;
      if (!n && !i)  t = {5'd0, b, p, e, fld[11:0]};
      else if (e)    t = fld;
      else if (b)    t = base_reg + {8'd0, fld[11:0]};
      else if (p)    t = pc + 20'd3 + {{8{fld[11]}}, fld[11:0]};
      else           t = {8'd0, fld[11:0]};
      if (x) t = t + idx_reg;
      return t;
   endfunction

   task automatic drive(logic [1:0] sl, logic n, logic i, logic x, logic b,
                        logic p, logic e, logic [19:0] fld);
      short_len = sl; f_n = n; f_i = i; f_x = x; f_b = b; f_p = p; f_e = e;
      field = fld;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic issue(string tag, logic [1:0] sl, logic n, logic i, logic x,
                        logic b, logic p, logic e, logic [19:0] fld);
      exp_t ex;
      logic [19:0] t;
      logic bad;
      t   = ref_ta(n, i, x, b, p, e, fld);
      bad = (sl == 0) && (n || i) && b && p;
      ex.tag   = tag;
      ex.cyc0  = cyc;
      ex.ra    = t;
      ex.err   = bad;
      ex.imm   = (sl == 0) && !bad && !n && i;
      ex.reads = ((sl == 0) && !bad && n && !i) ? 1 : 0;
      if (sl != 0)               ex.len = {1'b0, sl};
      else if ((n || i) && e)    ex.len = 3'd4;
      else                       ex.len = 3'd3;
      if (sl != 0 || bad)        ex.addr = '0;
      else if (ex.reads == 1)    ex.addr = t ^ 20'h35A5A;
      else                       ex.addr = t;
      exp_q.push_back(ex);
      drive(sl, n, i, x, b, p, e, fld);
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (done || mem_req || imm_valid || err || len != 0 || addr != 0) begin
         fails++;
         $display("FAIL R1: done=%b req=%b imm=%b err=%b len=%0d addr=%h expected all zero",
                  done, mem_req, imm_valid, err, len, addr);
      end

      pc = 20'h00100; base_reg = 20'hFFF00; idx_reg = 20'h00010;
      issue("R2 one-byte",   2'd1, 1, 1, 1, 1, 0, 1, 20'h12345);
      issue("R2 two-byte",   2'd2, 1, 0, 0, 0, 0, 0, 20'h00300);
      issue("R3 base wrap",  2'd0, 1, 1, 0, 1, 0, 0, 20'h00200);
      base_reg = 20'h01000;
      issue("R3 base max",   2'd0, 1, 1, 0, 1, 0, 0, 20'h00FFF);
      issue("R4 pc neg",     2'd0, 1, 1, 0, 0, 1, 0, 20'h00800);
      issue("R4 pc pos",     2'd0, 1, 1, 0, 0, 1, 0, 20'h007FF);
      issue("R5 direct",     2'd0, 1, 1, 0, 0, 0, 0, 20'hFF123);
      issue("R5 indexed",    2'd0, 1, 1, 1, 0, 0, 0, 20'h00123);
      issue("R6 long",       2'd0, 1, 1, 0, 1, 0, 1, 20'hABCDE);
      idx_reg = 20'h54322;
      issue("R6 long idx",   2'd0, 1, 1, 1, 0, 1, 1, 20'hABCDE);
      idx_reg = 20'h00010;
      issue("R7 immediate",  2'd0, 0, 1, 0, 0, 0, 0, 20'h0005A);
      issue("R7 imm base",   2'd0, 0, 1, 0, 1, 0, 0, 20'h00020);
      issue("R8 indirect",   2'd0, 1, 0, 0, 0, 0, 0, 20'h00300);
      issue("R8 ind pc",     2'd0, 1, 0, 0, 0, 1, 0, 20'h00FF0);
      issue("R9 legacy",     2'd0, 0, 0, 0, 1, 0, 1, 20'h00234);
      issue("R9 legacy idx", 2'd0, 0, 0, 1, 1, 1, 1, 20'h00FFF);
      issue("R10 simple bp", 2'd0, 1, 1, 0, 1, 1, 0, 20'h00444);
      issue("R10 ind bp",    2'd0, 1, 0, 0, 1, 1, 0, 20'h00444);

      // R11: a second start during a pending read must be ignored
      begin
         exp_t ex;
         ex.tag = "R11 busy start"; ex.cyc0 = cyc; ex.ra = 20'h00777;
         ex.addr = 20'h00777 ^ 20'h35A5A; ex.len = 3'd3; ex.imm = 1'b0;
         ex.err = 1'b0; ex.reads = 1;
         exp_q.push_back(ex);
         drive(2'd0, 1, 0, 0, 0, 0, 0, 20'h00777);
         drive(2'd1, 1, 1, 0, 1, 1, 1, 20'h00999);
         while (exp_q.size() != 0) @(negedge clk);
         repeat (6) @(negedge clk);
      end

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule